// File: doc/BRIEF.md
# Three-Phase Complementary Dead-Time Generator

This block turns three already-filtered PWM phase levels into six switch drives, one top and one bottom per phase of an inverter bridge. The top drive follows the phase level and the bottom drive follows its complement. Every rising edge on either drive is held back by a programmable underlap, so that neither switch of a pair turns on until the other has been off for that interval. Falling edges are not held back.

The underlap is set by a 6-bit code in units of a carrier tick, a single-cycle strobe supplied from outside. The code is inverted: all ones gives one tick and all zeros gives sixty-four ticks. The code and the tick are shared by all three phases. A registered gating stage after the delay forces every drive low while reset is high, while the trip flag is high or while the active-low inhibit is low. The inhibit masks only the drives. The delay counters keep running, so a release of the inhibit in the middle of a pulse lets the drive resume at once, even as a short runt.

Top module: `dtg_bridge`

## Requirements
- R1: With the gates open, top_o[i] settles to phase_i[i] and bot_o[i] settles to the inverse of phase_i[i], with a latency of two clock edges from the edge that samples the phase.
- R2: A leg whose level (phase_i[i] for the top leg, its inverse for the bottom leg) goes high counts tick_i pulses sampled while the level stays high. The leg turns on at the edge that samples tick number pdy, and the output goes high one edge later. pdy = 64 - dly_code_i, so code 6'b111111 gives pdy 1 and code 6'b000000 gives pdy 64.
- R3: A leg whose level is sampled low turns off at once, and its output goes low one edge later, with no added delay. top_o[i] and bot_o[i] are never high in the same cycle.
- R4: If the level of a leg falls before its count completes, the count restarts from zero. A high interval shorter than the underlap therefore never appears at the output.
- R5: An edge that samples inh_n_i low drives all six outputs low at that edge. The delay counters keep running during the inhibit, so the edge that samples inh_n_i high again restores every leg that is still on, even partway through a pulse.
- R6: An edge that samples trip_i high drives all six outputs low at that edge.
- R7: An edge that samples rst high clears every delay counter and drives all six outputs low.
- R8: The three phases run independently of one another and share dly_code_i and tick_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tick_i | input | 1 | Carrier unit tick, one-cycle strobe |
| dly_code_i | input | 6 | Inverted underlap code (pdy = 64 - code) |
| inh_n_i | input | 1 | Output inhibit, active low |
| trip_i | input | 1 | Trip flag, high forces outputs low |
| phase_i | input | 3 | Filtered PWM levels, one bit per phase |
| top_o | output | 3 | Top switch drives |
| bot_o | output | 3 | Bottom switch drives |

## Verification
Two functions can act in the same cycle. One is the gating stage releasing an inhibit or applying a trip. The other is a delay count completing and a leg turning on. The bench places the inhibit release and the trip assertion on the exact cycles where a short underlap completes, and it also places them in the middle of pulses and in the middle of counts. A behavioural reference model of counters and gates is compared with all six outputs on every clock. The rules that no pair is ever high together and that no rise appears without a high level two edges earlier are checked separately.

// File: rtl/dtg_pkg.sv
package dtg_pkg;

    localparam int CODE_W = 6;
    localparam int NPH    = 3;

    typedef logic [CODE_W-1:0] dly_code_t;

    typedef struct packed {
        dly_code_t cnt;
        logic      on;
    } leg_state_t;

    typedef struct packed {
        logic top;
        logic bot;
    } leg_pair_t;

    // count value at which the pdy-th tick completes: pdy-1 = (2^W - code) - 1 = ~code
    function automatic dly_code_t last_count(input dly_code_t code);
        return ~code;
    endfunction

    function automatic logic gate_open(input logic rst, input logic trip, input logic inh_n);
        return !rst && !trip && inh_n;
    endfunction

endpackage

// File: rtl/dtg_leg.sv
module dtg_leg
    import dtg_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      tick_i,
    input  dly_code_t code_i,
    input  logic      level_i,
    output logic      on_o
);

    leg_state_t st_q, st_d;

    always_comb begin
        st_d = st_q;
        if (!level_i) begin
            st_d = '0;
        end else if (!st_q.on && tick_i) begin
            if (st_q.cnt == last_count(code_i)) begin
                st_d.on = 1'b1;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign on_o = st_q.on;

endmodule

// File: rtl/dtg_phase.sv
module dtg_phase
    import dtg_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      tick_i,
    input  dly_code_t code_i,
    input  logic      phase_i,
    output leg_pair_t raw_o
);

    dtg_leg top_leg_i (
        .clk     (clk),
        .rst     (rst),
        .tick_i  (tick_i),
        .code_i  (code_i),
        .level_i (phase_i),
        .on_o    (raw_o.top)
    );

    dtg_leg bot_leg_i (
        .clk     (clk),
        .rst     (rst),
        .tick_i  (tick_i),
        .code_i  (code_i),
        .level_i (!phase_i),
        .on_o    (raw_o.bot)
    );

endmodule

// File: rtl/dtg_gate.sv
module dtg_gate
    import dtg_pkg::*;
#(
    parameter int N = NPH
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         trip_i,
    input  logic         inh_n_i,
    input  leg_pair_t    raw_i [N],
    output logic [N-1:0] top_o,
    output logic [N-1:0] bot_o
);

    logic open_w;
    assign open_w = gate_open(rst, trip_i, inh_n_i);

    for (genvar g = 0; g < N; g++) begin : g_gate
        always_ff @(posedge clk) begin
            top_o[g] <= open_w && raw_i[g].top;
            bot_o[g] <= open_w && raw_i[g].bot;
        end
    end

endmodule

// File: rtl/dtg_bridge.sv
module dtg_bridge
    import dtg_pkg::*;
#(
    parameter int N = NPH
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         tick_i,
    input  logic [5:0]   dly_code_i,
    input  logic         inh_n_i,
    input  logic         trip_i,
    input  logic [N-1:0] phase_i,
    output logic [N-1:0] top_o,
    output logic [N-1:0] bot_o
);

    leg_pair_t raw_w [N];

    for (genvar p = 0; p < N; p++) begin : g_phase
        dtg_phase phase_i_inst (
            .clk     (clk),
            .rst     (rst),
            .tick_i  (tick_i),
            .code_i  (dly_code_t'(dly_code_i)),
            .phase_i (phase_i[p]),
            .raw_o   (raw_w[p])
        );
    end

    dtg_gate #(.N(N)) gate_i (
        .clk     (clk),
        .rst     (rst),
        .trip_i  (trip_i),
        .inh_n_i (inh_n_i),
        .raw_i   (raw_w),
        .top_o   (top_o),
        .bot_o   (bot_o)
    );

endmodule

// File: rtl/dtg_bridge_chk.sv
module dtg_bridge_chk #(
    parameter int N = 3
) (
    input logic         clk,
    input logic         rst,
    input logic         trip_i,
    input logic         inh_n_i,
    input logic [N-1:0] phase_i,
    input logic [N-1:0] top_o,
    input logic [N-1:0] bot_o
);

    logic rst_q;
    always_ff @(posedge clk) rst_q <= rst;

    always @(negedge clk) begin
        if (rst_q === 1'b1) begin
            p_rst_low_r7: assert (top_o == '0 && bot_o == '0)
                else $error("outputs high after reset edge");
        end
    end

    p_no_shoot_r3: assert property (@(posedge clk) disable iff (rst)
        (top_o & bot_o) == '0);

    p_trip_low_r6: assert property (@(posedge clk) disable iff (rst)
        trip_i |=> (top_o == '0 && bot_o == '0));

    p_inh_low_r5: assert property (@(posedge clk) disable iff (rst)
        !inh_n_i |=> (top_o == '0 && bot_o == '0));

    for (genvar g = 0; g < N; g++) begin : g_ph
        p_fall_top_r3: assert property (@(posedge clk) disable iff (rst)
            !phase_i[g] |=> ##1 !top_o[g]);
        p_fall_bot_r3: assert property (@(posedge clk) disable iff (rst)
            phase_i[g] |=> ##1 !bot_o[g]);
        p_rise_top_r2: assert property (@(posedge clk) disable iff (rst)
            $rose(top_o[g]) |-> $past(phase_i[g], 2));
        p_rise_bot_r2: assert property (@(posedge clk) disable iff (rst)
            $rose(bot_o[g]) |-> !$past(phase_i[g], 2));
    end

endmodule

bind dtg_bridge dtg_bridge_chk #(.N(N)) chk_i (
    .clk     (clk),
    .rst     (rst),
    .trip_i  (trip_i),
    .inh_n_i (inh_n_i),
    .phase_i (phase_i),
    .top_o   (top_o),
    .bot_o   (bot_o)
);

// File: tb/dtg_bridge_tb_top.sv
`timescale 1ns/1ps
module dtg_bridge_tb_top;

    localparam int NP = 3;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          tick_i = 1'b0;
    logic [5:0]    dly_code_i = 6'd63;
    logic          inh_n_i = 1'b1;
    logic          trip_i = 1'b0;
    logic [NP-1:0] phase_i = '0;
    logic [NP-1:0] top_o, bot_o;

    int    checks = 0;
    int    fails  = 0;
    int    tick_div = 1;
    int    tick_cnt = 0;
    bit    cmp_en = 1'b0;
    bit    done = 1'b0;
    string cur_req = "R7";

    // reference state, index 0..2 top legs, 3..5 bottom legs
    int cnt_m [6];
    bit on_m  [6];
    bit out_m [6];

    always #4 clk = ~clk;

    dtg_bridge dut_i (
        .clk        (clk),
        .rst        (rst),
        .tick_i     (tick_i),
        .dly_code_i (dly_code_i),
        .inh_n_i    (inh_n_i),
        .trip_i     (trip_i),
        .phase_i    (phase_i),
        .top_o      (top_o),
        .bot_o      (bot_o)
    );

    always @(posedge clk) begin
        int pdy;
        bit open;
        bit lvl;
        pdy  = 64 - int'(dly_code_i);
        open = !rst && !trip_i && inh_n_i;
        for (int k = 0; k < 6; k++) begin
            out_m[k] = open && on_m[k];
            lvl = (k < 3) ? phase_i[k] : !phase_i[k-3];
            if (rst || !lvl) begin
                cnt_m[k] = 0;
                on_m[k]  = 0;
            end else if (!on_m[k] && tick_i) begin
                cnt_m[k]++;
                if (cnt_m[k] >= pdy) on_m[k] = 1;
            end
        end
    end

    always @(negedge clk) begin
        if (tick_cnt + 1 >= tick_div) begin
            tick_i   <= 1'b1;
            tick_cnt <= 0;
        end else begin
            tick_i   <= 1'b0;
            tick_cnt <= tick_cnt + 1;
        end
    end

    always @(negedge clk) begin
        if (cmp_en && !done) begin
            logic [NP-1:0] et, eb;
            for (int k = 0; k < NP; k++) begin
                et[k] = out_m[k];
                eb[k] = out_m[k+3];
            end
            checks++;
            if (top_o !== et || bot_o !== eb) begin
                fails++;
                $display("FAIL %s t=%0t top=%b bot=%b expected top=%b bot=%b",
                         cur_req, $time, top_o, bot_o, et, eb);
            end
        end
    end

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic run_pattern(input int len, input int seed);
        logic [15:0] lfsr;
        lfsr = 16'(seed) | 16'h1;
        for (int i = 0; i < len; i++) begin
            @(negedge clk);
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            if (lfsr[3:0] == 4'h0) phase_i[0] = ~phase_i[0];
            if (lfsr[7:5] == 3'h2) phase_i[1] = ~phase_i[1];
            if (lfsr[11:8] == 4'h5) phase_i[2] = ~phase_i[2];
        end
    endtask

    initial begin
        fork
            begin
                for (int k = 0; k < 6; k++) begin
                    cnt_m[k] = 0; on_m[k] = 0; out_m[k] = 0;
                end
                cyc(4);
                // R7: reset state
                checks++;
                if (top_o !== '0 || bot_o !== '0) begin
                    fails++;
                    $display("FAIL R7 reset state top=%b bot=%b expected 000/000", top_o, bot_o);
                end
                cmp_en = 1'b1;
                rst = 1'b0;

                // R1 R2 R3: shortest underlap, tick every cycle
                cur_req = "R1/R2/R3 pdy=1";
                dly_code_i = 6'd63; tick_div = 1;
                cyc(3);
                phase_i = 3'b101; cyc(10);
                phase_i = 3'b010; cyc(10);
                run_pattern(400, 16'hACE1);

                // R2: longest underlap
                cur_req = "R2 pdy=64";
                dly_code_i = 6'd0;
                phase_i = 3'b000; cyc(80);
                phase_i = 3'b111; cyc(80);
                phase_i = 3'b001; cyc(140);

                // R4: short pulses swallowed, slow tick
                cur_req = "R4 swallow";
                dly_code_i = 6'd59; tick_div = 3;
                for (int i = 0; i < 6; i++) begin
                    phase_i = 3'b111; cyc(8);
                    phase_i = 3'b000; cyc(9);
                end
                phase_i = 3'b111; cyc(30);
                run_pattern(600, 16'h1234);

                // R5: inhibit mid pulse and released as a rise completes
                cur_req = "R5 inhibit";
                dly_code_i = 6'd60; tick_div = 1;
                phase_i = 3'b000; cyc(12);
                phase_i = 3'b111; cyc(2);
                inh_n_i = 1'b0; cyc(3);
                inh_n_i = 1'b1; cyc(6);
                inh_n_i = 1'b0; cyc(4);
                phase_i = 3'b000; cyc(2);
                inh_n_i = 1'b1; cyc(8);
                for (int i = 0; i < 10; i++) begin
                    phase_i = ~phase_i; inh_n_i = 1'b0; cyc(i + 1);
                    inh_n_i = 1'b1; cyc(4);
                end

                // R6: trip with counts completing
                cur_req = "R6 trip";
                dly_code_i = 6'd63;
                phase_i = 3'b000; cyc(5);
                phase_i = 3'b111; trip_i = 1'b1; cyc(1);
                trip_i = 1'b0; cyc(5);
                trip_i = 1'b1; cyc(3);
                trip_i = 1'b0; inh_n_i = 1'b0; cyc(2);
                trip_i = 1'b1; inh_n_i = 1'b1; cyc(2);
                trip_i = 1'b0; cyc(5);

                // R7: reset in the middle of counts
                cur_req = "R7 mid reset";
                dly_code_i = 6'd50; tick_div = 2;
                phase_i = 3'b101; cyc(10);
                rst = 1'b1; cyc(2);
                rst = 1'b0; cyc(40);

                // R8: independent phases, mixed pattern with gating
                cur_req = "R8 mix";
                dly_code_i = 6'd58; tick_div = 1;
                fork
                    run_pattern(1500, 16'hBEEF);
                    begin
                        for (int i = 0; i < 30; i++) begin
                            cyc(37); inh_n_i = 1'b0; cyc(i % 5 + 1); inh_n_i = 1'b1;
                            cyc(11); trip_i = 1'b1; cyc(1); trip_i = 1'b0;
                        end
                    end
                join
                cyc(4);
            end
            begin
                repeat (100000) @(posedge clk);
                checks++;
                fails++;
                $display("FAIL watchdog expired in %s", cur_req);
            end
        join_any
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule